// File: doc/BRIEF.md
# Tunable PTP Time-of-Day Clock

This block keeps a precision time-of-day value: a 48-bit seconds count and a 32-bit nanoseconds count. A hidden 32-bit fraction of a nanosecond sits below them. On every rising edge of the reference clock the nanosecond part, together with its fraction, advances by a programmable period. The period has an integer nanosecond part and 32 fractional bits, so the average rate can be tuned in steps of 2^-32 ns with no long-term drift. When the nanoseconds reach one billion, they fold back and the seconds advance in the same edge.

Software reaches the clock through a single-cycle register write port. It can do three things. It can stage a full time of day and commit it at once, including an 8-bit sub-nanosecond fraction. It can stage and commit a new period. It can start a timed slew: a signed step, in units of 2^-8 ns, is added to the period for a programmed number of cycles, and then the nominal period returns. A time-of-day commit wins over that edge's accumulation and stops any slew in progress.

Top module: `ptp_tune_clock`

## Requirements
- R1: While reset is high and on the first edge after it, seconds and nanoseconds read 0. The period after reset is RST_PINT ns (5 ns by default) with a zero fraction.
- R2: Each rising edge with no time commit adds the current period to {nanoseconds, fraction}. The outputs are registered and show the new value after that edge.
- R3: When the sum reaches or exceeds 1,000,000,000 ns, 1,000,000,000 is subtracted and seconds increment in the same edge. Nanoseconds stay below 1,000,000,000.
- R4: Time commit. Address 0 stages seconds[47:32] from data[15:0]. Address 1 stages seconds[31:0]. Address 2 stages nanoseconds. A write to address 3 loads the staged seconds and nanoseconds, with data[7:0] as the top 8 fraction bits and the lower fraction bits cleared, and this replaces that edge's accumulation.
- R5: Period commit. Address 4 stages the integer period from data[7:0]. A write to address 5 commits {staged integer, data[31:0] as fraction}. The edge of the write still uses the old period, and the new period applies from the next edge.
- R6: The full 32-bit period fraction accumulates. A period of 1 + 2^-9 ns reads 511 ns after 511 edges and 513 ns after 512 edges.
- R7: Slew. Address 6 stages a signed 16-bit step in units of 2^-8 ns from data[15:0]. A write to address 7 captures that step and loads data[31:0] as a cycle count. Each of the next count edges adds period + step, and the period alone is used afterwards.
- R8: A write of 0 to address 7 ends a running slew. The edge of that write still applies the step.
- R9: A time commit cancels a running slew. Every later edge adds the nominal period.
- R10: Writes to staging addresses 0, 1, 2, 4 and 6 leave the outputs and the running rate unchanged until the matching commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the time advances on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Register address (0 to 7, see R4, R5, R7) |
| wr_data | input | 32 | Register write data |
| tod_sec | output | 48 | Seconds of the time of day |
| tod_ns | output | 32 | Nanoseconds of the time of day, always below 1e9 |

## Verification
Two pairs of functions can fall in the same edge. A time commit can land while a slew is counting down. A nanosecond rollover can happen during a slewed cycle or straight after a commit. The bench commits a time three edges into a 100-cycle slew, then counts the nanoseconds over the following edges; any leftover step would show up in that count. It also loads a time a few nanoseconds below the second boundary while a slew or a fractional carry is pending, and compares the folded nanoseconds and the incremented seconds against a reference model stepped in lockstep with the design.

// File: rtl/ptp_tune_clock_pkg.sv
package ptp_tune_clock_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_SEC_HIGH  = 3'd0,
      RA_SEC_LOW   = 3'd1,
      RA_NSEC      = 3'd2,
      RA_TIME_GO   = 3'd3,
      RA_RATE_INT  = 3'd4,
      RA_RATE_GO   = 3'd5,
      RA_SLEW_STEP = 3'd6,
      RA_SLEW_GO   = 3'd7
   } reg_addr_e;

endpackage

// File: rtl/ptc_write_port.sv
module ptc_write_port
   import ptp_tune_clock_pkg::*;
#(
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned SEC_W    = 48,
   parameter int unsigned NS_W     = 32,
   parameter int unsigned SUBNS_W  = 8,
   parameter int unsigned PINT_W   = 8,
   parameter int unsigned PFRAC_W  = 32,
   parameter int unsigned STEP_W   = 16,
   parameter int unsigned TMR_W    = 32,
   parameter int unsigned RST_PINT = 5
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]      wr_data,
   output logic                  time_go,
   output logic [SEC_W-1:0]      time_sec,
   output logic [NS_W-1:0]       time_ns,
   output logic [SUBNS_W-1:0]    time_sub,
   output logic [PINT_W-1:0]     rate_int,
   output logic [PFRAC_W-1:0]    rate_frac,
   output logic                  slew_go,
   output logic [STEP_W-1:0]     slew_step,
   output logic [TMR_W-1:0]      slew_cycles
);

   localparam int unsigned SEC_HI_W = SEC_W - BUS_W;
   localparam int unsigned NREG     = 1 << REG_ADDR_W;

   logic [NREG-1:0]     hit;
   logic [SEC_HI_W-1:0] sec_hi_stg;
   logic [BUS_W-1:0]    sec_lo_stg;
   logic [NS_W-1:0]     ns_stg;
   logic [PINT_W-1:0]   pint_stg;
   logic [STEP_W-1:0]   step_stg;
   logic [PINT_W-1:0]   pint_q;
   logic [PFRAC_W-1:0]  pfrac_q;

   // one select line per register address
   for (genvar a = 0; a < NREG; a++) begin : g_hit
      assign hit[a] = wr_en && (wr_addr == REG_ADDR_W'(a));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sec_hi_stg <= '0;
         sec_lo_stg <= '0;
         ns_stg     <= '0;
         pint_stg   <= PINT_W'(RST_PINT);
         step_stg   <= '0;
         pint_q     <= PINT_W'(RST_PINT);
         pfrac_q    <= '0;
      end else begin
         if (hit[RA_SEC_HIGH])  sec_hi_stg <= wr_data[SEC_HI_W-1:0];
         if (hit[RA_SEC_LOW])   sec_lo_stg <= wr_data;
         if (hit[RA_NSEC])      ns_stg     <= wr_data[NS_W-1:0];
         if (hit[RA_RATE_INT])  pint_stg   <= wr_data[PINT_W-1:0];
         if (hit[RA_SLEW_STEP]) step_stg   <= wr_data[STEP_W-1:0];
         if (hit[RA_RATE_GO]) begin
            pint_q  <= pint_stg;
            pfrac_q <= wr_data[PFRAC_W-1:0];
         end
      end
   end

   // commits act in the edge of the write itself
   assign time_go     = hit[RA_TIME_GO];
   assign time_sec    = {sec_hi_stg, sec_lo_stg};
   assign time_ns     = ns_stg;
   assign time_sub    = wr_data[SUBNS_W-1:0];
   assign rate_int    = pint_q;
   assign rate_frac   = pfrac_q;
   assign slew_go     = hit[RA_SLEW_GO];
   assign slew_step   = step_stg;
   assign slew_cycles = wr_data[TMR_W-1:0];

   p_rate_commit_r5 : assert property (@(posedge clk) disable iff (rst)
      hit[RA_RATE_GO] |=> (rate_frac == $past(wr_data[PFRAC_W-1:0])))
      else $error("rate fraction not committed");

   p_rate_hold_r10 : assert property (@(posedge clk) disable iff (rst)
      (!hit[RA_RATE_GO]) |=> ($stable(rate_int) && $stable(rate_frac)))
      else $error("rate changed without commit");

endmodule

// File: rtl/ptc_slew_ctrl.sv
module ptc_slew_ctrl #(
   parameter int unsigned PINT_W    = 8,
   parameter int unsigned PFRAC_W   = 32,
   parameter int unsigned STEP_W    = 16,
   parameter int unsigned STEP_FRAC = 8,
   parameter int unsigned TMR_W     = 32,
   parameter int unsigned INC_INT_W = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [PINT_W-1:0]    rate_int,
   input  logic [PFRAC_W-1:0]   rate_frac,
   input  logic                 slew_go,
   input  logic [STEP_W-1:0]    slew_step,
   input  logic [TMR_W-1:0]     slew_cycles,
   input  logic                 time_go,
   output logic [INC_INT_W-1:0] inc_ns,
   output logic [PFRAC_W-1:0]   inc_frac
);

   localparam int unsigned EW = INC_INT_W + PFRAC_W + 1;

   logic [TMR_W-1:0]     left_q;
   logic [STEP_W-1:0]    step_q;
   logic                 active;
   logic signed [EW-1:0] step_ext;
   logic signed [EW-1:0] step_al;
   logic signed [EW-1:0] rate_ext;
   logic signed [EW-1:0] inc;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
         step_q <= '0;
      end else if (time_go) begin
         left_q <= '0;
      end else if (slew_go) begin
         left_q <= slew_cycles;
         step_q <= slew_step;
      end else if (active) begin
         left_q <= left_q - TMR_W'(1);
      end
   end

   assign active   = (left_q != '0);
   assign step_ext = {{(EW-STEP_W){step_q[STEP_W-1]}}, step_q};

   // align the step's binary point with the period fraction
   if (STEP_FRAC <= PFRAC_W) begin : g_step_up
      assign step_al = step_ext <<< (PFRAC_W - STEP_FRAC);
   end else begin : g_step_down
      assign step_al = step_ext >>> (STEP_FRAC - PFRAC_W);
   end

   assign rate_ext = {{(EW-PINT_W-PFRAC_W){1'b0}}, rate_int, rate_frac};
   assign inc      = rate_ext + (active ? step_al : '0);
   assign inc_ns   = inc[EW-2:PFRAC_W];
   assign inc_frac = inc[PFRAC_W-1:0];

   p_inc_positive_r7 : assert property (@(posedge clk) disable iff (rst)
      active |-> !inc[EW-1])
      else $error("slewed period went negative");

   p_count_down_r7 : assert property (@(posedge clk) disable iff (rst)
      (active && !time_go && !slew_go) |=> (left_q == $past(left_q) - TMR_W'(1)))
      else $error("slew counter did not step");

   p_slew_start_r7 : assert property (@(posedge clk) disable iff (rst)
      (slew_go && !time_go) |=> (left_q == $past(slew_cycles)))
      else $error("slew count not loaded");

   p_time_cancels_r9 : assert property (@(posedge clk) disable iff (rst)
      time_go |=> !active)
      else $error("slew survived a time commit");

endmodule

// File: rtl/ptc_tod_accum.sv
module ptc_tod_accum #(
   parameter int unsigned SEC_W      = 48,
   parameter int unsigned NS_W       = 32,
   parameter int unsigned SUBNS_W    = 8,
   parameter int unsigned PFRAC_W    = 32,
   parameter int unsigned INC_INT_W  = 9,
   parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [INC_INT_W-1:0] inc_ns,
   input  logic [PFRAC_W-1:0]   inc_frac,
   input  logic                 time_go,
   input  logic [SEC_W-1:0]     time_sec,
   input  logic [NS_W-1:0]      time_ns,
   input  logic [SUBNS_W-1:0]   time_sub,
   output logic [SEC_W-1:0]     sec_q,
   output logic [NS_W-1:0]      ns_q
);

   localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

   logic [PFRAC_W-1:0] frac_q;
   logic [PFRAC_W-1:0] load_frac;
   logic [PFRAC_W:0]   frac_sum;
   logic [NS_W:0]      ns_sum;
   logic               wrap;
   logic [NS_W-1:0]    ns_nx;
   logic               load_d;

   // sub-nanosecond load value sits at the top of the fraction
   if (SUBNS_W == PFRAC_W) begin : g_frac_full
      assign load_frac = time_sub;
   end else begin : g_frac_pad
      assign load_frac = {time_sub, {(PFRAC_W-SUBNS_W){1'b0}}};
   end

   always_comb begin
      frac_sum = {1'b0, frac_q} + {1'b0, inc_frac};
      ns_sum   = {1'b0, ns_q} + (NS_W+1)'(inc_ns) + (NS_W+1)'(frac_sum[PFRAC_W]);
      wrap     = (ns_sum >= NS_LIM);
      ns_nx    = NS_W'(wrap ? (ns_sum - NS_LIM) : ns_sum);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sec_q  <= '0;
         ns_q   <= '0;
         frac_q <= '0;
         load_d <= 1'b0;
      end else begin
         load_d <= time_go;
         if (time_go) begin
            sec_q  <= time_sec;
            ns_q   <= time_ns;
            frac_q <= load_frac;
         end else begin
            ns_q   <= ns_nx;
            frac_q <= frac_sum[PFRAC_W-1:0];
            if (wrap) sec_q <= sec_q + SEC_W'(1);
         end
      end
   end

   p_ns_range_r3 : assert property (@(posedge clk) disable iff (rst)
      ((ns_q < NS_W'(NS_PER_SEC)) && !time_go) |=> (ns_q < NS_W'(NS_PER_SEC)))
      else $error("nanoseconds out of range");

   p_sec_step_r3 : assert property (@(posedge clk) disable iff (rst)
      (!time_go) |=> ((sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_W'(1))))
      else $error("seconds jumped");

   p_carry_fold_r3 : assert property (@(posedge clk) disable iff (rst)
      (!load_d && (sec_q != $past(sec_q))) |-> (ns_q < $past(ns_q)))
      else $error("seconds carry without nanosecond fold");

   p_time_load_r4 : assert property (@(posedge clk) disable iff (rst)
      time_go |=> ((sec_q == $past(time_sec)) && (ns_q == $past(time_ns))))
      else $error("time commit not loaded");

endmodule

// File: rtl/ptp_tune_clock.sv
module ptp_tune_clock
   import ptp_tune_clock_pkg::*;
#(
   parameter int unsigned BUS_W      = 32,
   parameter int unsigned SEC_W      = 48,
   parameter int unsigned NS_W       = 32,
   parameter int unsigned SUBNS_W    = 8,
   parameter int unsigned PINT_W     = 8,
   parameter int unsigned PFRAC_W    = 32,
   parameter int unsigned STEP_W     = 16,
   parameter int unsigned STEP_FRAC  = 8,
   parameter int unsigned TMR_W      = 32,
   parameter int unsigned RST_PINT   = 5,
   parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]      wr_data,
   output logic [SEC_W-1:0]      tod_sec,
   output logic [NS_W-1:0]       tod_ns
);

   localparam int unsigned STEP_INT_W = (STEP_W > STEP_FRAC) ? (STEP_W - STEP_FRAC) : 1;
   localparam int unsigned INC_INT_W  = ((PINT_W > STEP_INT_W) ? PINT_W : STEP_INT_W) + 1;

   if (SEC_W <= BUS_W || SEC_W > 2 * BUS_W) begin : g_bad_sec
      $error("SEC_W must lie in (BUS_W, 2*BUS_W]");
   end
   if (NS_W > BUS_W || PFRAC_W > BUS_W || TMR_W > BUS_W || STEP_W > BUS_W) begin : g_bad_bus
      $error("register fields must fit in BUS_W");
   end
   if (SUBNS_W > PFRAC_W || SUBNS_W > BUS_W || PINT_W > BUS_W) begin : g_bad_sub
      $error("sub-nanosecond or rate field too wide");
   end
   if (INC_INT_W >= NS_W || NS_PER_SEC >= (64'd1 << NS_W)) begin : g_bad_ns
      $error("nanosecond field too narrow");
   end

   logic                  time_go;
   logic [SEC_W-1:0]      time_sec;
   logic [NS_W-1:0]       time_ns;
   logic [SUBNS_W-1:0]    time_sub;
   logic [PINT_W-1:0]     rate_int;
   logic [PFRAC_W-1:0]    rate_frac;
   logic                  slew_go;
   logic [STEP_W-1:0]     slew_step;
   logic [TMR_W-1:0]      slew_cycles;
   logic [INC_INT_W-1:0]  inc_ns;
   logic [PFRAC_W-1:0]    inc_frac;

   ptc_write_port #(
      .BUS_W(BUS_W), .SEC_W(SEC_W), .NS_W(NS_W), .SUBNS_W(SUBNS_W),
      .PINT_W(PINT_W), .PFRAC_W(PFRAC_W), .STEP_W(STEP_W), .TMR_W(TMR_W),
      .RST_PINT(RST_PINT)
   ) u_port (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .time_go(time_go), .time_sec(time_sec), .time_ns(time_ns), .time_sub(time_sub),
      .rate_int(rate_int), .rate_frac(rate_frac),
      .slew_go(slew_go), .slew_step(slew_step), .slew_cycles(slew_cycles)
   );

   ptc_slew_ctrl #(
      .PINT_W(PINT_W), .PFRAC_W(PFRAC_W), .STEP_W(STEP_W), .STEP_FRAC(STEP_FRAC),
      .TMR_W(TMR_W), .INC_INT_W(INC_INT_W)
   ) u_slew (
      .clk(clk), .rst(rst), .rate_int(rate_int), .rate_frac(rate_frac),
      .slew_go(slew_go), .slew_step(slew_step), .slew_cycles(slew_cycles),
      .time_go(time_go), .inc_ns(inc_ns), .inc_frac(inc_frac)
   );

   ptc_tod_accum #(
      .SEC_W(SEC_W), .NS_W(NS_W), .SUBNS_W(SUBNS_W), .PFRAC_W(PFRAC_W),
      .INC_INT_W(INC_INT_W), .NS_PER_SEC(NS_PER_SEC)
   ) u_accum (
      .clk(clk), .rst(rst), .inc_ns(inc_ns), .inc_frac(inc_frac),
      .time_go(time_go), .time_sec(time_sec), .time_ns(time_ns), .time_sub(time_sub),
      .sec_q(tod_sec), .ns_q(tod_ns)
   );

   p_reset_zero_r1 : assert property (@(posedge clk)
      rst |=> ((tod_sec == '0) && (tod_ns == '0)))
      else $error("time not cleared by reset");

endmodule

// File: tb/ptp_tune_clock_tb.sv
`timescale 1ns/1ps
module ptp_tune_clock_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [47:0] tod_sec;
   logic [31:0] tod_ns;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   ptp_tune_clock u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tod_sec(tod_sec), .tod_ns(tod_ns)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
         $finish;
      end
   end

   // reference model state, stepped once per edge
   logic [47:0] m_sec, st_sec;
   logic [31:0] m_ns, m_frac, st_ns, m_pfrac, m_cnt;
   logic [7:0]  m_pint, st_pint;
   logic [15:0] st_step, m_step;

   task automatic model_reset();
      m_sec = '0; m_ns = '0; m_frac = '0; st_sec = '0; st_ns = '0;
      m_pint = 8'd5; st_pint = 8'd5; m_pfrac = '0; m_cnt = '0;
      st_step = '0; m_step = '0;
   endtask

   task automatic model_step(input bit we, input logic [2:0] a, input logic [31:0] d);
      longint inc, tot;
      logic [31:0] nsn;
      if (we && a == 3'd3) begin
         m_sec = st_sec; m_ns = st_ns; m_frac = {d[7:0], 24'h0}; m_cnt = '0;
      end else begin
         inc = longint'({m_pint, m_pfrac});
         if (m_cnt != 0) begin
            inc = inc + longint'($signed(m_step)) * 64'sd16777216;
            m_cnt = m_cnt - 1;
         end
         tot = longint'({m_ns, m_frac}) + inc;
         nsn = tot[63:32];
         if (nsn >= 32'd1000000000) begin
            nsn = nsn - 32'd1000000000;
            m_sec = m_sec + 1;
         end
         m_ns = nsn; m_frac = tot[31:0];
         if (we && a == 3'd7) begin m_cnt = d; m_step = st_step; end
      end
      if (we) begin
         case (a)
            3'd0: st_sec[47:32] = d[15:0];
            3'd1: st_sec[31:0]  = d;
            3'd2: st_ns   = d;
            3'd4: st_pint = d[7:0];
            3'd5: begin m_pint = st_pint; m_pfrac = d; end
            3'd6: st_step = d[15:0];
            default: ;
         endcase
      end
   endtask

   task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d);
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_step(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_model(input string tag);
      check({tag, " sec"}, 64'(tod_sec), 64'(m_sec));
      check({tag, " ns"},  64'(tod_ns),  64'(m_ns));
   endtask

   // {we, addr, data, idle cycles, requirement number}
   localparam int NV = 13;
   localparam logic [47:0] VEC [NV] = '{
      {1'b1, 3'd4, 32'd8,          8'd0, 4'd10}, // R10 staged integer only
      {1'b1, 3'd5, 32'h8000_0000,  8'd3, 4'd5},  // R5 period 8.5 ns
      {1'b1, 3'd1, 32'd100,        8'd0, 4'd10}, // R10 staging seconds
      {1'b1, 3'd0, 32'd0,          8'd0, 4'd10}, // R10
      {1'b1, 3'd2, 32'd999999990,  8'd0, 4'd10}, // R10
      {1'b1, 3'd3, 32'h80,         8'd2, 4'd3},  // R4 load, R3 rollover
      {1'b1, 3'd6, 32'h0000_FF00,  8'd0, 4'd10}, // R10 step -1 ns staged
      {1'b1, 3'd7, 32'd4,          8'd6, 4'd7},  // R7 four slewed cycles
      {1'b1, 3'd6, 32'h0000_0180,  8'd0, 4'd10}, // R10 step +1.5 ns staged
      {1'b1, 3'd7, 32'd10,         8'd2, 4'd7},  // R7
      {1'b1, 3'd3, 32'h40,         8'd5, 4'd9},  // R9 commit during slew
      {1'b1, 3'd7, 32'd5,          8'd1, 4'd7},  // R7
      {1'b1, 3'd7, 32'd0,          8'd4, 4'd8}   // R8 cancel by zero count
   };

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset sec", 64'(tod_sec), 64'd0);
      check("R1 reset ns",  64'(tod_ns),  64'd0);
      rst = 1'b0;
      repeat (4) cyc(1'b0, 3'd0, 32'd0);
      // R1 R2: default 5 ns period
      check("R2 default period ns", 64'(tod_ns), 64'd20);

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][47], VEC[i][46:44], VEC[i][43:12]);
         for (int k = 0; k < int'(VEC[i][11:4]); k++) cyc(1'b0, 3'd0, 32'd0);
         check_model($sformatf("R%0d vector %0d", VEC[i][3:0], i));
      end

      // R4 R3: load near the second boundary, upper seconds word in use
      cyc(1'b1, 3'd4, 32'd5);
      cyc(1'b1, 3'd5, 32'd0);
      cyc(1'b1, 3'd0, 32'd1);
      cyc(1'b1, 3'd1, 32'd7);
      cyc(1'b1, 3'd2, 32'd999999997);
      check_model("R10 staging leaves time running");
      cyc(1'b1, 3'd3, 32'd0);
      check("R4 loaded sec", 64'(tod_sec), 64'h1_0000_0007);
      check("R4 loaded ns",  64'(tod_ns),  64'd999999997);
      cyc(1'b0, 3'd0, 32'd0);
      check("R3 folded ns",  64'(tod_ns),  64'd2);
      check("R3 carried sec", 64'(tod_sec), 64'h1_0000_0008);

      // R6: period 1 + 2^-9 ns keeps the deep fraction bits
      cyc(1'b1, 3'd4, 32'd1);
      cyc(1'b1, 3'd5, 32'h0080_0000);
      cyc(1'b1, 3'd0, 32'd0);
      cyc(1'b1, 3'd1, 32'd0);
      cyc(1'b1, 3'd2, 32'd0);
      cyc(1'b1, 3'd3, 32'd0);
      repeat (511) cyc(1'b0, 3'd0, 32'd0);
      check("R6 after 511 edges", 64'(tod_ns), 64'd511);
      cyc(1'b0, 3'd0, 32'd0);
      check("R6 after 512 edges", 64'(tod_ns), 64'd513);

      // R9: time commit three edges into a 100-cycle +2 ns slew
      cyc(1'b1, 3'd4, 32'd10);
      cyc(1'b1, 3'd5, 32'd0);
      cyc(1'b1, 3'd6, 32'h0000_0200);
      cyc(1'b1, 3'd7, 32'd100);
      repeat (3) cyc(1'b0, 3'd0, 32'd0);
      cyc(1'b1, 3'd3, 32'd0);
      repeat (4) cyc(1'b0, 3'd0, 32'd0);
      check("R9 slew cancelled by commit", 64'(tod_ns), 64'd40);

      // R8: zero count ends the slew, its own edge still slewed
      cyc(1'b1, 3'd3, 32'd0);
      cyc(1'b1, 3'd7, 32'd50);
      repeat (2) cyc(1'b0, 3'd0, 32'd0);
      cyc(1'b1, 3'd7, 32'd0);
      repeat (3) cyc(1'b0, 3'd0, 32'd0);
      check("R8 zero count stop", 64'(tod_ns), 64'd76);

      // R7: -1 ns for exactly three edges
      cyc(1'b1, 3'd3, 32'd0);
      cyc(1'b1, 3'd6, 32'h0000_FF00);
      cyc(1'b1, 3'd7, 32'd3);
      repeat (5) cyc(1'b0, 3'd0, 32'd0);
      check("R7 slew expiry", 64'(tod_ns), 64'd67);
      check_model("R7 model agreement");

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule